// File: doc/BRIEF.md
# Branch Resolve Unit

This block holds the program counter of a five-stage in-order pipeline, together with the control-flow side of that pipeline. Every cycle the front end fetches at the current PC and moves on to PC+1 the next cycle, so the unit in effect always guesses that a branch falls through. The incremented address captured at fetch moves with its instruction through three stage registers: decode, register read and execute. The decoder supplies the branch class and a 4-bit offset while the instruction sits in decode. Both values join the stage record from the register-read stage onward.

Branches are resolved in the execute stage. The unit checks a two-bit flag register holding the negative and zero flags. The instruction ahead of the branch writes that register at the end of its own execute cycle. A taken branch sends the next fetch to its carried PC+1 plus the sign-extended offset. In the same cycle it kills the three younger instructions in fetch, decode and register read. Those instructions keep their contents but lose their valid bits, so they can write no registers, memory, flags or PC. A branch that is not taken costs nothing.

Top module: `branch_resolve_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `fetch_addr` equals the reset address (0 by default), the three stage valid outputs are 0, and `br_taken` and the three kill outputs are 0.
- R2: In any cycle without a taken branch, `fetch_addr` in the next cycle is the current value plus one, modulo 2^PW.
- R3: An instruction fetched at address A in cycle t is in execute in cycle t+3 with `ex_valid`=1 and `ex_pc_inc`=A+1, unless it was killed on the way.
- R4: Branch class codes on `dec_kind` are 00 for no branch (never taken), 01 for taken if N is 0, 10 for taken if Z is 1, and 11 for taken if Z is 0. An execute stage with `ex_valid`=0 is never taken.
- R5: `br_target` equals `ex_pc_inc` plus the 4-bit offset sign-extended to PW bits (bit 3 is the sign), modulo 2^PW.
- R6: In the cycle after `br_taken` is 1, `fetch_addr` equals the `br_target` of that cycle. This replaces the increment.
- R7: When `br_taken` is 1, `kill_fetch`, `kill_decode` and `kill_regread` are all 1 in that cycle. In the next cycle `de_valid`, `rf_valid` and `ex_valid` are all 0. The pipeline then refills at one stage per cycle.
- R8: The flag register loads `ex_neg` and `ex_zero` at the end of a cycle in which `ex_flag_we`=1 and `ex_valid`=1. The write request is ignored while `ex_valid`=0, and a branch tests the flags as they stood at the start of its execute cycle.
- R9: A branch that is not taken causes no kill. In the next cycle `de_valid`=1 and the instructions behind it keep moving.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_kind | input | 2 | Branch class of the instruction in decode |
| dec_offset | input | 4 | Branch offset of the instruction in decode (two's complement) |
| ex_flag_we | input | 1 | Instruction in execute writes the flags this cycle |
| ex_neg | input | 1 | New negative flag from the execute stage |
| ex_zero | input | 1 | New zero flag from the execute stage |
| fetch_addr | output | PW | Address being fetched this cycle |
| de_valid | output | 1 | Decode stage holds a live instruction |
| rf_valid | output | 1 | Register-read stage holds a live instruction |
| ex_valid | output | 1 | Execute stage holds a live instruction |
| ex_pc_inc | output | PW | Carried PC+1 of the instruction in execute |
| br_taken | output | 1 | Execute-stage branch is taken |
| br_target | output | PW | Redirect address for a taken branch |
| kill_fetch | output | 1 | Discard the instruction in fetch |
| kill_decode | output | 1 | Discard the instruction in decode |
| kill_regread | output | 1 | Discard the instruction in register read |

## Verification
A slip in the carried PC+1 chain or in the offset extension shows up as a wrong `br_target` three cycles after fetch. The next cycle it also shows up as a wrong `fetch_addr`. A flag register that records a write from a killed slot shows up only when the next branch reaches execute, at least four cycles later. That case is provoked on purpose, with a conditional branch as the redirect target. A valid bit that survives a kill shows up at once as a stage valid output that is still 1 in the cycle after `br_taken`.

// File: rtl/br_pkg.sv
// Package br_pkg
// Shared branch class encoding for the branch resolve unit.
// Assumes a two-bit class field produced by the instruction decoder.
package br_pkg;

    typedef enum logic [1:0] {
        BR_NONE    = 2'b00,
        BR_NOTNEG  = 2'b01,
        BR_ZERO    = 2'b10,
        BR_NONZERO = 2'b11
    } br_kind_e;

endpackage

// File: rtl/br_fetch_pc.sv
// Module br_fetch_pc
// Holds the fetch program counter. Each cycle it advances to PC+1 unless
// a redirect from the execute stage supplies a new address.
// Assumes fetch never stalls; the redirect has priority over the increment.
module br_fetch_pc #(
    parameter int          PW       = 8,
    parameter logic [PW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          redirect,
    input  logic [PW-1:0] redirect_addr,
    output logic [PW-1:0] pc_now,
    output logic [PW-1:0] pc_inc
);

    logic [PW-1:0] pc_q;
    logic [PW-1:0] pc_d;

    // Fall-through address of the instruction being fetched.
    always_comb begin
        pc_inc = pc_q + PW'(1);
    end

    // Pick the next fetch address: redirect wins over fall-through.
    always_comb begin
        pc_d = redirect ? redirect_addr : pc_inc;
    end

    // PC register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign pc_now = pc_q;

endmodule

// File: rtl/br_stage_pipe.sv
// Module br_stage_pipe
// Carries each instruction's PC+1 and a valid bit through the decode,
// register-read and execute stage registers. Branch class and offset
// join from the decoder at the register-read stage.
// Assumes no stall; a squash clears valid bits only, contents still load.
module br_stage_pipe
    import br_pkg::*;
#(
    parameter int PW   = 8,
    parameter int IW   = 4,
    parameter int NSTG = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            squash,
    input  logic [PW-1:0]   fetch_inc,
    input  br_kind_e        dec_kind,
    input  logic [IW-1:0]   dec_imm,
    output logic [NSTG-1:0] stg_valid,
    output logic [PW-1:0]   ex_pc,
    output br_kind_e        ex_kind,
    output logic [IW-1:0]   ex_imm
);

    localparam int LAST = NSTG - 1;
    localparam int NTAG = NSTG - 1;

    logic [PW-1:0] pc_q   [NSTG];
    logic [NSTG-1:0] vld_q;
    br_kind_e      kind_q [NTAG];
    logic [IW-1:0] imm_q  [NTAG];

    genvar k;
    generate
        for (k = 0; k < NSTG; k++) begin : g_pc
            if (k == 0) begin : g_head
                // First stage takes the fetch PC+1; a live slot unless squashed.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        pc_q[k]  <= '0;
                        vld_q[k] <= 1'b0;
                    end else begin
                        pc_q[k]  <= fetch_inc;
                        vld_q[k] <= !squash;
                    end
                end
            end else begin : g_body
                // Later stages shift the previous stage forward.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        pc_q[k]  <= '0;
                        vld_q[k] <= 1'b0;
                    end else begin
                        pc_q[k]  <= pc_q[k-1];
                        vld_q[k] <= vld_q[k-1] && !squash;
                    end
                end
            end
        end

        for (k = 0; k < NTAG; k++) begin : g_tag
            if (k == 0) begin : g_cap
                // Capture decoder outputs as the instruction leaves decode.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        kind_q[k] <= BR_NONE;
                        imm_q[k]  <= '0;
                    end else begin
                        kind_q[k] <= dec_kind;
                        imm_q[k]  <= dec_imm;
                    end
                end
            end else begin : g_fwd
                // Move branch class and offset along with the PC.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        kind_q[k] <= BR_NONE;
                        imm_q[k]  <= '0;
                    end else begin
                        kind_q[k] <= kind_q[k-1];
                        imm_q[k]  <= imm_q[k-1];
                    end
                end
            end
        end
    endgenerate

    assign stg_valid = vld_q;
    assign ex_pc     = pc_q[LAST];
    assign ex_kind   = kind_q[NTAG-1];
    assign ex_imm    = imm_q[NTAG-1];

endmodule

// File: rtl/br_cond_eval.sv
// Module br_cond_eval
// Decides whether the branch in execute is taken from its class and the
// current flag register. Purely combinational.
// Assumes the flags reflect the instruction just ahead of the branch.
module br_cond_eval
    import br_pkg::*;
(
    input  logic     live,
    input  br_kind_e kind,
    input  logic     flag_n,
    input  logic     flag_z,
    output logic     taken
);

    logic cond_ok;

    // Map each branch class to its flag test.
    always_comb begin
        unique case (kind)
            BR_NOTNEG:  cond_ok = !flag_n;
            BR_ZERO:    cond_ok = flag_z;
            BR_NONZERO: cond_ok = !flag_z;
            default:    cond_ok = 1'b0;
        endcase
    end

    // Only a live instruction may redirect.
    always_comb begin
        taken = live && cond_ok;
    end

endmodule

// File: rtl/br_target_calc.sv
// Module br_target_calc
// Forms the branch target: carried PC+1 plus the sign-extended offset.
// Assumes PW is wider than IW; the sum wraps modulo 2^PW.
module br_target_calc #(
    parameter int PW = 8,
    parameter int IW = 4
) (
    input  logic [PW-1:0] pc_inc,
    input  logic [IW-1:0] offset,
    output logic [PW-1:0] target
);

    localparam int EXT = PW - IW;

    logic [PW-1:0] offset_ext;

    // Replicate the offset sign bit up to the PC width.
    always_comb begin
        offset_ext = {{EXT{offset[IW-1]}}, offset};
    end

    // Add the extended offset to the carried fall-through address.
    always_comb begin
        target = pc_inc + offset_ext;
    end

endmodule

// File: rtl/branch_resolve_unit.sv
// Module branch_resolve_unit
// Top of the branch resolve unit: fetch PC, PC+1 stage chain, flag
// register, execute-stage condition test, target adder and kill outputs.
// Assumes fetch predicts fall-through every cycle and that a taken branch
// in execute discards the three younger stages.
module branch_resolve_unit
    import br_pkg::*;
#(
    parameter int            PW       = 8,
    parameter int            IW       = 4,
    parameter logic [PW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    dec_kind,
    input  logic [IW-1:0] dec_offset,
    input  logic          ex_flag_we,
    input  logic          ex_neg,
    input  logic          ex_zero,
    output logic [PW-1:0] fetch_addr,
    output logic          de_valid,
    output logic          rf_valid,
    output logic          ex_valid,
    output logic [PW-1:0] ex_pc_inc,
    output logic          br_taken,
    output logic [PW-1:0] br_target,
    output logic          kill_fetch,
    output logic          kill_decode,
    output logic          kill_regread
);

    localparam int NSTG = 3;

    logic [PW-1:0]   pc_inc;
    logic [NSTG-1:0] stg_valid;
    br_kind_e        ex_kind;
    logic [IW-1:0]   ex_imm;
    logic            flag_n_q;
    logic            flag_z_q;
    logic            taken;
    logic [PW-1:0]   target;

    br_fetch_pc #(
        .PW       (PW),
        .RESET_PC (RESET_PC)
    ) u_fetch_pc (
        .clk           (clk),
        .rst_n         (rst_n),
        .redirect      (taken),
        .redirect_addr (target),
        .pc_now        (fetch_addr),
        .pc_inc        (pc_inc)
    );

    br_stage_pipe #(
        .PW   (PW),
        .IW   (IW),
        .NSTG (NSTG)
    ) u_stage_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .squash    (taken),
        .fetch_inc (pc_inc),
        .dec_kind  (br_kind_e'(dec_kind)),
        .dec_imm   (dec_offset),
        .stg_valid (stg_valid),
        .ex_pc     (ex_pc_inc),
        .ex_kind   (ex_kind),
        .ex_imm    (ex_imm)
    );

    // Flag register: written only by a live instruction in execute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_n_q <= 1'b0;
            flag_z_q <= 1'b0;
        end else if (ex_flag_we && stg_valid[NSTG-1]) begin
            flag_n_q <= ex_neg;
            flag_z_q <= ex_zero;
        end
    end

    br_cond_eval u_cond_eval (
        .live   (stg_valid[NSTG-1]),
        .kind   (ex_kind),
        .flag_n (flag_n_q),
        .flag_z (flag_z_q),
        .taken  (taken)
    );

    br_target_calc #(
        .PW (PW),
        .IW (IW)
    ) u_target_calc (
        .pc_inc (ex_pc_inc),
        .offset (ex_imm),
        .target (target)
    );

    // Drive stage status and kill outputs.
    always_comb begin
        de_valid     = stg_valid[0];
        rf_valid     = stg_valid[1];
        ex_valid     = stg_valid[2];
        br_taken     = taken;
        br_target    = target;
        kill_fetch   = taken;
        kill_decode  = taken;
        kill_regread = taken;
    end

endmodule

// File: rtl/br_resolve_sva.sv
// Module br_resolve_sva
// Property checker for branch_resolve_unit, attached through bind.
// Assumes synchronous active-low reset; all checks are off during reset.
module br_resolve_sva #(
    parameter int PW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [PW-1:0] fetch_addr,
    input logic          de_valid,
    input logic          rf_valid,
    input logic          ex_valid,
    input logic          br_taken,
    input logic [PW-1:0] br_target,
    input logic          kill_fetch,
    input logic          kill_decode,
    input logic          kill_regread
);

    assert_fallthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !br_taken |=> (fetch_addr == PW'($past(fetch_addr) + PW'(1))));

    assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_valid && !br_taken) |=> ex_valid);

    assert_dead_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid |-> !br_taken);

    assert_redirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> (fetch_addr == $past(br_target)));

    assert_kill_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> (kill_fetch && kill_decode && kill_regread));

    assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> (!de_valid && !rf_valid && !ex_valid));

    assert_no_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !br_taken |=> de_valid);

endmodule

bind branch_resolve_unit br_resolve_sva #(.PW(PW)) u_br_resolve_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_addr   (fetch_addr),
    .de_valid     (de_valid),
    .rf_valid     (rf_valid),
    .ex_valid     (ex_valid),
    .br_taken     (br_taken),
    .br_target    (br_target),
    .kill_fetch   (kill_fetch),
    .kill_decode  (kill_decode),
    .kill_regread (kill_regread)
);

// File: tb/test_branch_resolve_unit.sv
`timescale 1ns/1ps
module test_branch_resolve_unit;

    localparam int PW = 8;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    dec_kind = 2'b00;
    logic [IW-1:0] dec_offset = '0;
    logic          ex_flag_we = 1'b0;
    logic          ex_neg = 1'b0;
    logic          ex_zero = 1'b0;
    logic [PW-1:0] fetch_addr;
    logic          de_valid, rf_valid, ex_valid;
    logic [PW-1:0] ex_pc_inc;
    logic          br_taken;
    logic [PW-1:0] br_target;
    logic          kill_fetch, kill_decode, kill_regread;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    branch_resolve_unit i_branch_resolve_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .dec_kind     (dec_kind),
        .dec_offset   (dec_offset),
        .ex_flag_we   (ex_flag_we),
        .ex_neg       (ex_neg),
        .ex_zero      (ex_zero),
        .fetch_addr   (fetch_addr),
        .de_valid     (de_valid),
        .rf_valid     (rf_valid),
        .ex_valid     (ex_valid),
        .ex_pc_inc    (ex_pc_inc),
        .br_taken     (br_taken),
        .br_target    (br_target),
        .kill_fetch   (kill_fetch),
        .kill_decode  (kill_decode),
        .kill_regread (kill_regread)
    );

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, actual, expected, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        dec_kind   = 2'b00;
        dec_offset = '0;
        ex_flag_we = 1'b0;
        ex_neg     = 1'b0;
        ex_zero    = 1'b0;
    endtask

    // Apply reset; return in the first cycle after release (cycle c0).
    task automatic do_reset();
        idle_inputs();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    // R1: reset state during and after reset.
    task automatic t_reset();
        idle_inputs();
        rst_n = 1'b0;
        step();
        step();
        check(fetch_addr == 8'd0, "R1 addr in reset", fetch_addr, 0);
        check({de_valid, rf_valid, ex_valid} == 3'b000, "R1 valids in reset",
              {de_valid, rf_valid, ex_valid}, 0);
        rst_n = 1'b1;
        check(fetch_addr == 8'd0, "R1 addr after release", fetch_addr, 0);
        check({br_taken, kill_fetch, kill_decode, kill_regread} == 4'b0000,
              "R1 no kill after release", {br_taken, kill_fetch, kill_decode, kill_regread}, 0);
    endtask

    // R2 and R3: straight-line fetch, PC+1 arrives in execute three cycles later.
    task automatic t_straight();
        do_reset();
        for (int k = 0; k < 20; k++) begin
            check(fetch_addr == PW'(k), "R2 increment", fetch_addr, k);
            if (k >= 3) begin
                check(ex_valid == 1'b1, "R3 execute live", ex_valid, 1);
                check(ex_pc_inc == PW'(k - 2), "R3 carried pc", ex_pc_inc, k - 2);
            end
            step();
        end
    endtask

    // R4..R7, R9: one branch at address 1, flags set by the instruction at address 0.
    task automatic t_branch(input int kind, input bit n, input bit z, input logic [3:0] imm);
        bit exp_taken;
        int imm_s;
        logic [PW-1:0] exp_tgt;
        exp_taken = (kind == 1) ? !n : (kind == 2) ? z : (kind == 3) ? !z : 1'b0;
        imm_s   = imm[3] ? int'(imm) - 16 : int'(imm);
        exp_tgt = PW'(2 + imm_s);
        do_reset();                      // c0: fetch 0
        step();                          // c1: instr 0 in decode
        check(de_valid == 1'b1, "R9 decode live", de_valid, 1);
        step();                          // c2: instr 1 (branch) in decode
        dec_kind   = 2'(kind);
        dec_offset = imm;
        step();                          // c3: instr 0 in execute writes flags
        dec_kind   = 2'b00;
        dec_offset = '0;
        check(ex_valid == 1'b1 && ex_pc_inc == 8'd1, "R3 first in execute", ex_pc_inc, 1);
        check(br_taken == 1'b0, "R4 plain op not taken", br_taken, 0);
        ex_flag_we = 1'b1;
        ex_neg     = n;
        ex_zero    = z;
        step();                          // c4: branch in execute
        ex_flag_we = 1'b0;
        check(ex_pc_inc == 8'd2, "R3 branch pc", ex_pc_inc, 2);
        check(br_taken == exp_taken, "R4 decision", br_taken, exp_taken);
        check(br_target == exp_tgt, "R5 target", br_target, exp_tgt);
        check({kill_fetch, kill_decode, kill_regread} == {3{exp_taken}}, "R7 kill outputs",
              {kill_fetch, kill_decode, kill_regread}, exp_taken ? 7 : 0);
        step();                          // c5
        if (exp_taken) begin
            check(fetch_addr == exp_tgt, "R6 redirect", fetch_addr, exp_tgt);
            check({de_valid, rf_valid, ex_valid} == 3'b000, "R7 flushed",
                  {de_valid, rf_valid, ex_valid}, 0);
        end else begin
            check(fetch_addr == 8'd5, "R2 fall-through after branch", fetch_addr, 5);
            check({de_valid, rf_valid, ex_valid} == 3'b111, "R9 no loss",
                  {de_valid, rf_valid, ex_valid}, 7);
        end
    endtask

    // R8 and R7 refill: flag writes from killed slots are ignored.
    task automatic t_flag_guard();
        do_reset();
        step();                          // c1
        step();                          // c2: nonzero branch, offset +7
        dec_kind   = 2'b11;
        dec_offset = 4'd7;
        step();                          // c3: Z=0 written by live instr 0
        dec_kind   = 2'b00;
        dec_offset = '0;
        ex_flag_we = 1'b1;
        ex_neg     = 1'b0;
        ex_zero    = 1'b0;
        step();                          // c4: branch taken to 9
        ex_flag_we = 1'b0;
        check(br_taken == 1'b1 && br_target == 8'd9, "R8 nonzero uses Z=0", br_target, 9);
        step();                          // c5: dead execute; try to set Z
        check(fetch_addr == 8'd9, "R6 redirect to 9", fetch_addr, 9);
        check(kill_fetch == 1'b0, "R7 kill only once", kill_fetch, 0);
        ex_flag_we = 1'b1;
        ex_zero    = 1'b1;
        ex_neg     = 1'b1;
        step();                          // c6: target in decode, a zero branch
        check(de_valid == 1'b1 && rf_valid == 1'b0, "R7 refill decode",
              {de_valid, rf_valid}, 2);
        dec_kind   = 2'b10;
        dec_offset = 4'd1;
        step();                          // c7: still dead execute
        dec_kind   = 2'b00;
        dec_offset = '0;
        check(ex_valid == 1'b0 && br_taken == 1'b0, "R4 dead slot not taken", br_taken, 0);
        step();                          // c8: zero branch in execute
        ex_flag_we = 1'b0;
        ex_zero    = 1'b0;
        ex_neg     = 1'b0;
        check(ex_valid == 1'b1 && ex_pc_inc == 8'd10, "R3 target pc", ex_pc_inc, 10);
        check(br_taken == 1'b0, "R8 killed flag write ignored", br_taken, 0);
        step();                          // c9
        check(fetch_addr == 8'd13, "R2 continue after not taken", fetch_addr, 13);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_straight();
        for (int kd = 0; kd < 4; kd++) begin
            for (int f = 0; f < 4; f++) begin
                t_branch(kd, f[1], f[0], 4'hD);
                t_branch(kd, f[1], f[0], 4'h7);
            end
        end
        t_branch(1, 1'b0, 1'b0, 4'h8);
        t_flag_guard();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule